// File: doc/BRIEF.md
# Self-Routing Omega Interconnect

This block is an eight-port, three-stage, unbuffered multistage interconnect built from 2x2 switching elements. Once per slot, each input may offer one cell: a valid bit, a 3-bit destination port number and a payload. Ahead of every stage, a perfect-shuffle wiring permutes the links. Each element sets its own state (through or cross) from a single bit of the destination address of the cells it sees. No central controller configures the fabric, so it uses only N·log2(N)/2 elements instead of the N² crosspoints of a crossbar.

Two cells can ask for the same element output. This happens when they are headed to the same port. It can also happen when their destinations differ and their paths share an internal link. The element then passes the cell that arrived on its upper input and discards the other. For every input that offered a cell, the fabric reports one outcome in the slot where the delivered cells appear: an acknowledge, a loss on an internal link, or a loss because both cells wanted the same output port.

A parameter chooses one of two timings. In the first, the stages are purely combinational and only the outputs are registered. In the second, a register sits after every stage.

Top module: `omega_fabric`

## Requirements
- R1: While reset is asserted, and on the clock edge after it, every output of the block is zero: output valids, acknowledges and both loss flags.
- R2: A cell with no competitor appears on output port equal to its destination, carrying its payload and its source input number. The latency is 1 cycle when PIPE=0 and 3 cycles (one per stage) when PIPE=1.
- R3: Before each stage, link p feeds position rotate-left(p) of that stage (3-bit rotate). Position 2j is the upper input of element j and position 2j+1 is its lower input. Stage k (k=0,1,2) steers on destination bit 2-k: a 0 goes to the upper output and a 1 to the lower output. As a result, the identity and every uniform cyclic shift (input i to port (i+c) mod 8) pass with no loss.
- R4: When both inputs of one element request the same output, the cell on the upper input goes on and the cell on the lower input is dropped. Example: input 0 to port 3 together with input 4 to port 2 delivers input 0 and drops input 4.
- R5: ack_o bit i is 1 in exactly the cycle in which the cell from input i is presented on its destination port.
- R6: lost_link_o bit i is 1 in that same cycle when the cell from input i was dropped by a winner whose destination differs from its own.
- R7: lost_port_o bit i is 1 in that same cycle when the cell from input i was dropped by a winner with the same destination. Example: inputs 1 and 3 both sent to port 6 deliver input 1 and mark input 3.
- R8: For each input, at most one of ack, link loss and port loss is set. An input that offered no cell gets none of the three.
- R9: An input with valid low occupies no link: it neither blocks nor drops any other cell, whatever value is on its destination field.
- R10: A new slot can enter on every clock. The outcome of each slot depends only on the cells offered in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Per-input cell present |
| in_dest | input | 24 | Per-input destination, input i at bits [3i+2:3i] |
| in_data | input | 128 | Per-input payload, input i at bits [16i+15:16i] |
| out_valid | output | 8 | Per-output-port cell present |
| out_src | output | 24 | Source input of the cell on port p, at bits [3p+2:3p] |
| out_data | output | 128 | Payload on port p, at bits [16p+15:16p] |
| ack_o | output | 8 | Per-input delivery acknowledge |
| lost_link_o | output | 8 | Per-input drop on an internal link conflict |
| lost_port_o | output | 8 | Per-input drop on a same-destination conflict |

## Verification
In a single slot, delivery of the winning cell and the drop report for the losing cell come out together, often with an unrelated cell delivered through another element at the same time. Directed pairs trigger this: inputs 0/4 to ports 3/2 give a link loss, and inputs 1/3 both to port 6 give a port loss. A long run of back-to-back pseudo-random slots triggers it as well, because many inputs compete in the same cycle. The bench judges each slot with a path model written separately from the RTL. The model follows the window of the concatenated source and destination bits that names the link a cell holds after each stage, and it drops the cell whose source-side bit marks the lower input. It then compares delivered ports, payloads, sources, acknowledges and both loss vectors in the cycle the slot is due.

// File: rtl/omega_pkg.sv
package omega_pkg;

    localparam int PORT_AW   = 3;
    localparam int NPORTS    = 1 << PORT_AW;
    localparam int NSW       = NPORTS / 2;
    localparam int PAYLOAD_W = 16;

    typedef logic [PORT_AW-1:0] port_t;

    typedef struct packed {
        logic                 vld;
        port_t                dest;
        port_t                src;
        logic [PAYLOAD_W-1:0] data;
    } cell_t;

    typedef enum logic [1:0] {
        LOSS_NONE = 2'd0,
        LOSS_LINK = 2'd1,
        LOSS_PORT = 2'd2
    } loss_kind_e;

    typedef struct packed {
        loss_kind_e kind;
        port_t      src;
    } loss_t;

    typedef struct packed {
        logic [NPORTS-1:0] link;
        logic [NPORTS-1:0] port;
    } loss_vec_t;

    // destination bit that steers a given stage, most significant first
    function automatic logic route_bit(port_t dest, int stage);
        return dest[PORT_AW-1-stage];
    endfunction

    // link index a perfect shuffle moves position p to
    function automatic int shuffle_pos(int p);
        return ((p << 1) | (p >> (PORT_AW - 1))) & (NPORTS - 1);
    endfunction

endpackage

// File: rtl/omega_sw2.sv
module omega_sw2
    import omega_pkg::*;
#(
    parameter int STAGE = 0
) (
    input  cell_t up_i,
    input  cell_t dn_i,
    output cell_t up_o,
    output cell_t dn_o,
    output loss_t loss_o
);

    logic sel_up;
    logic sel_dn;
    logic clash;

    always_comb begin
        sel_up = route_bit(up_i.dest, STAGE);
        sel_dn = route_bit(dn_i.dest, STAGE);
        clash  = up_i.vld && dn_i.vld && (sel_up == sel_dn);

        up_o = '0;
        dn_o = '0;
        // upper input has priority and is placed first
        if (up_i.vld) begin
            if (sel_up) dn_o = up_i;
            else        up_o = up_i;
        end
        if (dn_i.vld && !clash) begin
            if (sel_dn) dn_o = dn_i;
            else        up_o = dn_i;
        end

        loss_o.src = dn_i.src;
        if (!clash)                    loss_o.kind = LOSS_NONE;
        else if (up_i.dest == dn_i.dest) loss_o.kind = LOSS_PORT;
        else                           loss_o.kind = LOSS_LINK;
    end

endmodule

// File: rtl/omega_column.sv
module omega_column
    import omega_pkg::*;
#(
    parameter int STAGE = 0
) (
    input  cell_t     cells_i [NPORTS],
    output cell_t     cells_o [NPORTS],
    output loss_vec_t loss_o
);

    cell_t shuf [NPORTS];
    loss_t sw_loss [NSW];

    for (genvar p = 0; p < NPORTS; p++) begin : g_shuffle
        localparam int DST = shuffle_pos(p);
        assign shuf[DST] = cells_i[p];
    end

    for (genvar j = 0; j < NSW; j++) begin : g_sw
        omega_sw2 #(.STAGE(STAGE)) u_sw (
            .up_i   (shuf[2*j]),
            .dn_i   (shuf[2*j+1]),
            .up_o   (cells_o[2*j]),
            .dn_o   (cells_o[2*j+1]),
            .loss_o (sw_loss[j])
        );
    end

    always_comb begin
        loss_o = '0;
        for (int j = 0; j < NSW; j++) begin
            if (sw_loss[j].kind == LOSS_LINK) loss_o.link[sw_loss[j].src] = 1'b1;
            if (sw_loss[j].kind == LOSS_PORT) loss_o.port[sw_loss[j].src] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric
    import omega_pkg::*;
#(
    parameter bit PIPE = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORTS-1:0]             in_valid,
    input  logic [NPORTS*PORT_AW-1:0]     in_dest,
    input  logic [NPORTS*PAYLOAD_W-1:0]   in_data,
    output logic [NPORTS-1:0]             out_valid,
    output logic [NPORTS*PORT_AW-1:0]     out_src,
    output logic [NPORTS*PAYLOAD_W-1:0]   out_data,
    output logic [NPORTS-1:0]             ack_o,
    output logic [NPORTS-1:0]             lost_link_o,
    output logic [NPORTS-1:0]             lost_port_o
);

    for (genvar k = 0; k < PORT_AW; k++) begin : g_stage
        cell_t     cin  [NPORTS];
        cell_t     cout [NPORTS];
        loss_vec_t ain;
        loss_vec_t aout;
        loss_vec_t lcol;

        if (k == 0) begin : g_src
            for (genvar i = 0; i < NPORTS; i++) begin : g_inj
                assign cin[i] = '{vld:  in_valid[i],
                                  dest: in_dest[i*PORT_AW +: PORT_AW],
                                  src:  port_t'(i),
                                  data: in_data[i*PAYLOAD_W +: PAYLOAD_W]};
            end
            assign ain = '0;
        end else if (PIPE) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int p = 0; p < NPORTS; p++) cin[p] <= '0;
                    ain <= '0;
                end else begin
                    for (int p = 0; p < NPORTS; p++) cin[p] <= g_stage[k-1].cout[p];
                    ain <= g_stage[k-1].aout;
                end
            end
        end else begin : g_wire
            assign cin = g_stage[k-1].cout;
            assign ain = g_stage[k-1].aout;
        end

        omega_column #(.STAGE(k)) u_col (
            .cells_i (cin),
            .cells_o (cout),
            .loss_o  (lcol)
        );

        assign aout.link = ain.link | lcol.link;
        assign aout.port = ain.port | lcol.port;
    end

    cell_t             fin [NPORTS];
    loss_vec_t         fin_loss;
    logic [NPORTS-1:0] ack_n;

    assign fin      = g_stage[PORT_AW-1].cout;
    assign fin_loss = g_stage[PORT_AW-1].aout;

    always_comb begin
        ack_n = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (fin[p].vld) ack_n[fin[p].src] = 1'b1;
        end
    end

    logic [NPORTS-1:0]    ov_q;
    logic [NPORTS-1:0]    ack_q;
    logic [NPORTS-1:0]    ll_q;
    logic [NPORTS-1:0]    lp_q;
    port_t                src_q  [NPORTS];
    logic [PAYLOAD_W-1:0] data_q [NPORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q  <= '0;
            ack_q <= '0;
            ll_q  <= '0;
            lp_q  <= '0;
            for (int p = 0; p < NPORTS; p++) begin
                src_q[p]  <= '0;
                data_q[p] <= '0;
            end
        end else begin
            ack_q <= ack_n;
            ll_q  <= fin_loss.link;
            lp_q  <= fin_loss.port;
            for (int p = 0; p < NPORTS; p++) begin
                ov_q[p]   <= fin[p].vld;
                src_q[p]  <= fin[p].src;
                data_q[p] <= fin[p].data;
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_out
        assign out_src[p*PORT_AW +: PORT_AW]      = src_q[p];
        assign out_data[p*PAYLOAD_W +: PAYLOAD_W] = data_q[p];
    end

    assign out_valid   = ov_q;
    assign ack_o       = ack_q;
    assign lost_link_o = ll_q;
    assign lost_port_o = lp_q;

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk
    import omega_pkg::*;
#(
    parameter bit PIPE = 1'b0
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NPORTS-1:0]         in_valid,
    input logic [NPORTS*PORT_AW-1:0] in_dest,
    input logic [NPORTS-1:0]         out_valid,
    input logic [NPORTS*PORT_AW-1:0] out_src,
    input logic [NPORTS-1:0]         ack_o,
    input logic [NPORTS-1:0]         lost_link_o,
    input logic [NPORTS-1:0]         lost_port_o
);

    localparam int LAT = PIPE ? PORT_AW : 1;

    logic [NPORTS-1:0]         vld_d  [LAT];
    logic [NPORTS*PORT_AW-1:0] dest_d [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++) begin
                vld_d[k]  <= '0;
                dest_d[k] <= '0;
            end
        end else begin
            vld_d[0]  <= in_valid;
            dest_d[0] <= in_dest;
            for (int k = 1; k < LAT; k++) begin
                vld_d[k]  <= vld_d[k-1];
                dest_d[k] <= dest_d[k-1];
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && ack_o == '0 && lost_link_o == '0 && lost_port_o == '0));

    for (genvar i = 0; i < NPORTS; i++) begin : g_in
        a_r8_single_outcome: assert property (@(posedge clk) disable iff (rst)
            $onehot0({ack_o[i], lost_link_o[i], lost_port_o[i]}));
        a_r8_outcome_iff_offered: assert property (@(posedge clk) disable iff (rst)
            (ack_o[i] || lost_link_o[i] || lost_port_o[i]) == vld_d[LAT-1][i]);
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        a_r2_lands_on_dest: assert property (@(posedge clk) disable iff (rst)
            out_valid[p] |->
                dest_d[LAT-1][out_src[p*PORT_AW +: PORT_AW]*PORT_AW +: PORT_AW] == port_t'(p));
        a_r5_ack_with_delivery: assert property (@(posedge clk) disable iff (rst)
            out_valid[p] |-> ack_o[out_src[p*PORT_AW +: PORT_AW]]);
    end

endmodule

bind omega_fabric omega_fabric_chk #(.PIPE(PIPE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_dest     (in_dest),
    .out_valid   (out_valid),
    .out_src     (out_src),
    .ack_o       (ack_o),
    .lost_link_o (lost_link_o),
    .lost_port_o (lost_port_o)
);

// File: tb/omega_fabric_tb_top.sv
`timescale 1ns/1ps
module omega_fabric_tb_top;
    import omega_pkg::*;

    localparam bit TB_PIPE = 1'b1;
    localparam int LAT     = TB_PIPE ? PORT_AW : 1;
    localparam int AW      = PORT_AW;
    localparam int DW      = PAYLOAD_W;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NPORTS-1:0]      in_valid = '0;
    logic [NPORTS*AW-1:0]   in_dest = '0;
    logic [NPORTS*DW-1:0]   in_data = '0;
    logic [NPORTS-1:0]      out_valid;
    logic [NPORTS*AW-1:0]   out_src;
    logic [NPORTS*DW-1:0]   out_data;
    logic [NPORTS-1:0]      ack_o;
    logic [NPORTS-1:0]      lost_link_o;
    logic [NPORTS-1:0]      lost_port_o;

    always #2.5 clk = ~clk;

    omega_fabric #(.PIPE(TB_PIPE)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
        .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
        .ack_o(ack_o), .lost_link_o(lost_link_o), .lost_port_o(lost_port_o)
    );

    typedef struct {
        logic [NPORTS-1:0]    ov;
        logic [NPORTS*AW-1:0] os;
        logic [NPORTS*DW-1:0] od;
        logic [NPORTS-1:0]    ack;
        logic [NPORTS-1:0]    ll;
        logic [NPORTS-1:0]    lp;
        int                   due;
        string                tag;
    } exp_t;

    exp_t  sb_q[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    int    slot_id = 0;
    bit    done = 1'b0;
    logic [31:0] rng = 32'h1234_abcd;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one slot at a falling edge and push its expected outcome
    task automatic drive_slot(input logic [NPORTS-1:0] v, input logic [NPORTS*AW-1:0] d,
                              input string tag);
        exp_t e;
        logic [NPORTS-1:0] alive;
        port_t lnk [NPORTS];
        logic [2*AW-1:0] x;
        logic [NPORTS*DW-1:0] data;
        for (int i = 0; i < NPORTS; i++) data[i*DW +: DW] = DW'(slot_id * 16 + i + 1);
        slot_id++;
        e.ov = '0; e.os = '0; e.od = '0; e.ack = '0; e.ll = '0; e.lp = '0;
        alive = v;
        for (int s = 0; s < AW; s++) begin
            for (int i = 0; i < NPORTS; i++) begin
                x = {port_t'(i), d[i*AW +: AW]};
                lnk[i] = x[2*AW-2-s -: AW];
            end
            for (int i = 0; i < NPORTS; i++) begin
                for (int j = i + 1; j < NPORTS; j++) begin
                    if (alive[i] && alive[j] && lnk[i] == lnk[j]) begin
                        int loser;
                        x = {port_t'(i), d[i*AW +: AW]};
                        loser = x[2*AW-1-s] ? i : j;
                        alive[loser] = 1'b0;
                        if (d[i*AW +: AW] == d[j*AW +: AW]) e.lp[loser] = 1'b1;
                        else                                e.ll[loser] = 1'b1;
                    end
                end
            end
        end
        for (int i = 0; i < NPORTS; i++) begin
            if (alive[i]) begin
                int p;
                p = int'(d[i*AW +: AW]);
                e.ov[p] = 1'b1;
                e.os[p*AW +: AW] = port_t'(i);
                e.od[p*DW +: DW] = data[i*DW +: DW];
                e.ack[i] = 1'b1;
            end
        end
        e.due = cyc + LAT;
        e.tag = tag;
        in_valid = v;
        in_dest  = d;
        in_data  = data;
        sb_q.push_back(e);
    endtask

    // monitor: compare due slots a little after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst && sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            logic [NPORTS*AW-1:0] as;
            logic [NPORTS*DW-1:0] ad;
            e = sb_q.pop_front();
            as = '0; ad = '0;
            for (int p = 0; p < NPORTS; p++) begin
                if (out_valid[p]) begin
                    as[p*AW +: AW] = out_src[p*AW +: AW];
                    ad[p*DW +: DW] = out_data[p*DW +: DW];
                end
            end
            check(out_valid == e.ov, {"R2 ", e.tag}, "out_valid", 256'(out_valid), 256'(e.ov));
            check(as == e.os && ad == e.od, {"R2 ", e.tag}, "source/payload",
                  256'({as, ad}), 256'({e.os, e.od}));
            check(ack_o == e.ack, {"R5 ", e.tag}, "ack", 256'(ack_o), 256'(e.ack));
            check(lost_link_o == e.ll, {"R6 ", e.tag}, "lost_link", 256'(lost_link_o), 256'(e.ll));
            check(lost_port_o == e.lp, {"R7 ", e.tag}, "lost_port", 256'(lost_port_o), 256'(e.lp));
            check(((ack_o & lost_link_o) | (ack_o & lost_port_o) | (lost_link_o & lost_port_o)) == '0,
                  {"R8 ", e.tag}, "outcome overlap", 256'({ack_o, lost_link_o, lost_port_o}), 256'(0));
        end
    end

    function automatic logic [NPORTS*AW-1:0] perm_shift(input int c);
        logic [NPORTS*AW-1:0] d;
        for (int i = 0; i < NPORTS; i++) d[i*AW +: AW] = port_t'((i + c) % NPORTS);
        return d;
    endfunction

    function automatic logic [NPORTS*AW-1:0] one_dest(input int i, input int dst);
        logic [NPORTS*AW-1:0] d;
        d = '0;
        d[i*AW +: AW] = port_t'(dst);
        return d;
    endfunction

    task automatic idle_slot(input string tag);
        @(negedge clk);
        drive_slot('0, '0, tag);
    endtask

    initial begin
        // reset with busy inputs: nothing may leak out (R1)
        in_valid = '1;
        in_dest  = perm_shift(2);
        repeat (3) @(negedge clk);
        check(out_valid == '0 && ack_o == '0 && lost_link_o == '0 && lost_port_o == '0,
              "R1", "outputs in reset", 256'({out_valid, ack_o, lost_link_o, lost_port_o}), 256'(0));
        rst = 1'b0;
        in_valid = '0;
        @(negedge clk);
        check(out_valid == '0 && ack_o == '0 && lost_link_o == '0 && lost_port_o == '0,
              "R1", "outputs after reset edge", 256'({out_valid, ack_o, lost_link_o, lost_port_o}), 256'(0));

        // R2: every input to every port, alone
        for (int i = 0; i < NPORTS; i++) begin
            for (int p = 0; p < NPORTS; p++) begin
                @(negedge clk);
                drive_slot(NPORTS'(1) << i, one_dest(i, p), "R2 lone cell");
            end
        end

        // R3: conflict-free permutations
        for (int c = 0; c < NPORTS; c++) begin
            @(negedge clk);
            drive_slot('1, perm_shift(c), "R3 cyclic shift");
        end

        // R4 and R6: internal link clash 0->3 with 4->2, upper (input 0) wins
        @(negedge clk);
        drive_slot(8'b0001_0001, one_dest(0, 3) | one_dest(4, 2), "R4 link clash");
        idle_slot("R8 idle");

        // R7: same destination, 1->6 and 3->6
        @(negedge clk);
        drive_slot(8'b0000_1010, one_dest(1, 6) | one_dest(3, 6), "R7 port clash");

        // R7: all inputs to port 5
        @(negedge clk);
        drive_slot('1, {NPORTS{3'd5}}, "R7 hotspot");

        // R9: invalid input 0 pointing at 3 must not block 4->2
        @(negedge clk);
        drive_slot(8'b0001_0000, one_dest(0, 3) | one_dest(4, 2), "R9 invalid no block");
        @(negedge clk);
        drive_slot(8'b0000_0010, {NPORTS{3'd6}}, "R9 only one valid");

        // R10: back-to-back pseudo-random slots
        for (int n = 0; n < 400; n++) begin
            logic [NPORTS*AW-1:0] d;
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            d = NPORTS*AW'(rng);
            @(negedge clk);
            drive_slot(rng[31:24], d, "R10 random stream");
        end

        idle_slot("R8 idle");
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule